// File: doc/BRIEF.md
# Eight-Pin Configurable I/O Port with Pin Takeover

This block is an eight-pin general-purpose I/O port that sits on a byte-wide peripheral register bus. Software sets the direction of each pin on its own through a write-only direction register. It drives output levels and samples pin levels through a data register that can be both read and written.

Three kinds of alternate function can claim pins away from the port:
- An auxiliary bus mode puts the low six bits of an I/O address onto the upper six pins.
- A slave-interface mode hands the same six pins to slave logic.
- Two serial-clock enables each claim one of the two lowest pins for a serial clock.

The register latches keep their contents while pins are claimed. The read path keeps returning pin levels, and with slave mode active the two top bits of a read return what the slave logic is driving. The serial ports, the slave logic and the bus controller live outside the block and reach it only as plain input signals.

Top module: `altio_port`

## Requirements
- R1: A bus write with the address equal to 0x40 loads the data latch on that clock edge. On every pin that is not claimed, pinOut carries the latch bit.
- R2: A bus write with the address equal to 0x47 loads the direction register on that clock edge. Direction bit i at 1 sets pinOe[i] to 1 (output), and at 0 sets it to 0 (input), on any pin that is not claimed.
- R3: While reset is held and right after it is released, the direction register holds 8'hC0 (pinOe = 8'hC0) and pinOut[7:6] is 0.
- R4: A read at address 0x47 returns 8'h00 and changes neither the direction register nor the latch. A read at any address other than 0x40 returns 8'h00.
- R5: A read at address 0x40 returns the pin levels after a two-flop synchronizer. A level change seen at the first rising edge is visible in the read after the second rising edge. A pin set as an output reads its pin level, not its latch.
- R6: With auxBusEn at 1, pins 7..2 drive auxIoAddr[5:0] (pin 2 carries bit 0) with pinOe forced to 1. Data-register writes do not change these pins.
- R7: With slaveEn at 1 and auxBusEn at 0, pins 7..2 drive slaveDrive[5:0] (pin 2 carries bit 0) with pinOe forced to 1. A data read returns slaveDrive[5:4] in bits 7:6 and the synchronized pin levels in bits 5:0.
- R8: With auxBusEn and slaveEn both at 1, pins 7..2 carry auxIoAddr.
- R9: serBClkEn at 1 makes pin 0 drive serBClk with pinOe[0] at 1. serAClkEn at 1 makes pin 1 drive serAClk with pinOe[1] at 1. Each of these wins over every other mode.
- R10: When every override is removed, each pin returns to the latch and the direction register, including latch writes made while the pin was claimed.
- R11: A bus write at an address that matches neither 0x40 nor 0x47 changes neither pinOut nor pinOe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register bus address |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data; 0 when not selected |
| auxBusEn | input | 1 | Auxiliary address-bus mode enable |
| auxIoAddr | input | 6 | Low six I/O address bits for pins 7..2 |
| slaveEn | input | 1 | Slave-interface mode enable |
| slaveDrive | input | 6 | Levels the slave logic drives onto pins 7..2 |
| serAClkEn | input | 1 | Serial A internal clock enable (pin 1) |
| serAClk | input | 1 | Serial A clock |
| serBClkEn | input | 1 | Serial B internal clock enable (pin 0) |
| serBClk | input | 1 | Serial B clock |
| pinIn | input | 8 | Pin levels |
| pinOut | output | 8 | Pin output levels |
| pinOe | output | 8 | Pin output enables, 1 = drive |

## Verification
The hardest case to reach is a data-register write made while the upper pins are claimed. Its effect is invisible at the pins until every override is dropped. The bench therefore writes a new latch value under auxiliary mode, checks that the pins still carry the address, then releases all modes and checks that the new latch value appears. The slave readback is also awkward, because pin bits and slave-driven bits mix in one byte. The bench applies distinct patterns to pinIn and slaveDrive, waits out the synchronizer, and checks the mixed result.

// File: rtl/altio_pkg.sv
package altio_pkg;

  typedef struct packed {
    logic dataWr;
    logic dirWr;
    logic dataRd;
  } portStrobeT;

endpackage

// File: rtl/altio_ctrl.sv
module altio_ctrl
  import altio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h40,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 8'h47
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output portStrobeT        strobes
);

  logic hitData;
  logic hitDir;

  assign hitData = (busAddr == DATA_ADDR);
  assign hitDir  = (busAddr == DIR_ADDR);

  always_comb begin
    strobes        = '0;
    strobes.dataWr = busWrEn & hitData;
    strobes.dirWr  = busWrEn & hitDir;
    strobes.dataRd = busRdEn & hitData;
  end

  // R1 R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.dataWr, strobes.dirWr}));

  // R4
  dir_rd_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == DIR_ADDR) |-> !strobes.dataRd);

endmodule

// File: rtl/altio_dp.sv
module altio_dp
  import altio_pkg::*;
#(
  parameter int PIN_W = 8,
  parameter logic [PIN_W-1:0] DIR_RST = 8'hC0,
  parameter logic [PIN_W-1:0] LATCH_RST = 8'h00,
  localparam int ALT_W = PIN_W - 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobeT       strobes,
  input  logic [PIN_W-1:0] wrData,
  input  logic             auxBusEn,
  input  logic [ALT_W-1:0] auxIoAddr,
  input  logic             slaveEn,
  input  logic [ALT_W-1:0] slaveDrive,
  input  logic             serAClkEn,
  input  logic             serAClk,
  input  logic             serBClkEn,
  input  logic             serBClk,
  input  logic [PIN_W-1:0] pinIn,
  output logic [PIN_W-1:0] pinOut,
  output logic [PIN_W-1:0] pinOe,
  output logic [PIN_W-1:0] rdData
);

  logic [PIN_W-1:0] dirReg;
  logic [PIN_W-1:0] latchReg;
  logic [PIN_W-1:0] syncA;
  logic [PIN_W-1:0] syncQ;
  logic [PIN_W-1:0] rdVal;
  logic             slaveEff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg   <= DIR_RST;
      latchReg <= LATCH_RST;
    end else begin
      if (strobes.dirWr)  dirReg   <= wrData;
      if (strobes.dataWr) latchReg <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    syncA <= pinIn;
    syncQ <= syncA;
  end

  assign slaveEff = slaveEn & ~auxBusEn;

  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    if (i == 0) begin : g_serb
      assign pinOut[i] = serBClkEn ? serBClk : latchReg[i];
      assign pinOe[i]  = serBClkEn | dirReg[i];
      assign rdVal[i]  = syncQ[i];
    end else if (i == 1) begin : g_sera
      assign pinOut[i] = serAClkEn ? serAClk : latchReg[i];
      assign pinOe[i]  = serAClkEn | dirReg[i];
      assign rdVal[i]  = syncQ[i];
    end else begin : g_alt
      assign pinOut[i] = auxBusEn ? auxIoAddr[i-2]
                       : slaveEn ? slaveDrive[i-2] : latchReg[i];
      assign pinOe[i]  = auxBusEn | slaveEn | dirReg[i];
      if (i >= PIN_W - 2) begin : g_top
        assign rdVal[i] = slaveEff ? slaveDrive[i-2] : syncQ[i];
      end else begin : g_low
        assign rdVal[i] = syncQ[i];
      end
    end
  end

  assign rdData = strobes.dataRd ? rdVal : '0;

  // R3
  rst_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (dirReg == DIR_RST));

  // R1
  data_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dataWr |=> (latchReg == $past(wrData)));

  // R2
  dir_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dirWr |=> (dirReg == $past(wrData)));

  // R4
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.dirWr |=> $stable(dirReg));

  // R11
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.dataWr |=> $stable(latchReg));

  // R9
  serial_pri_chk: assert property (@(posedge clk) disable iff (!rstN)
    serBClkEn |-> (pinOe[0] && pinOut[0] == serBClk));

endmodule

// File: rtl/altio_port.sv
module altio_port
  import altio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PIN_W = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h40,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 8'h47,
  parameter logic [PIN_W-1:0] DIR_RST = 8'hC0,
  parameter logic [PIN_W-1:0] LATCH_RST = 8'h00,
  localparam int ALT_W = PIN_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [PIN_W-1:0]  busWrData,
  output logic [PIN_W-1:0]  busRdData,
  input  logic              auxBusEn,
  input  logic [ALT_W-1:0]  auxIoAddr,
  input  logic              slaveEn,
  input  logic [ALT_W-1:0]  slaveDrive,
  input  logic              serAClkEn,
  input  logic              serAClk,
  input  logic              serBClkEn,
  input  logic              serBClk,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOe
);

  portStrobeT strobes;

  altio_ctrl #(
    .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .strobes(strobes)
  );

  altio_dp #(
    .PIN_W(PIN_W), .DIR_RST(DIR_RST), .LATCH_RST(LATCH_RST)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(busWrData),
    .auxBusEn(auxBusEn), .auxIoAddr(auxIoAddr), .slaveEn(slaveEn),
    .slaveDrive(slaveDrive), .serAClkEn(serAClkEn), .serAClk(serAClk),
    .serBClkEn(serBClkEn), .serBClk(serBClk), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .rdData(busRdData)
  );

endmodule

// File: tb/altio_port_tb.sv
module altio_port_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       auxBusEn = 1'b0;
  logic [5:0] auxIoAddr = '0;
  logic       slaveEn = 1'b0;
  logic [5:0] slaveDrive = '0;
  logic       serAClkEn = 1'b0;
  logic       serAClk = 1'b0;
  logic       serBClkEn = 1'b0;
  logic       serBClk = 1'b0;
  logic [7:0] pinIn = '0;
  logic [7:0] pinOut;
  logic [7:0] pinOe;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  altio_port dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .auxBusEn(auxBusEn), .auxIoAddr(auxIoAddr), .slaveEn(slaveEn),
    .slaveDrive(slaveDrive), .serAClkEn(serAClkEn), .serAClk(serAClk),
    .serBClkEn(serBClkEn), .serBClk(serBClk), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    #1;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1;
    d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
    #1;
  endtask

  task automatic setPins(input logic [7:0] v);
    @(negedge clk);
    pinIn = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] r;
    @(negedge clk); #1;
    check("R3 pinOe after reset", pinOe, 8'hC0);
    check("R3 pinOut[7:6] after reset", {6'b0, pinOut[7:6]}, 8'h00);
    busRead(8'h47, r);
    check("R4 dir read returns zero", r, 8'h00);
    check("R4 dir unchanged by read", pinOe, 8'hC0);
  endtask

  task automatic testDirData();
    busWrite(8'h47, 8'hFF);
    busWrite(8'h40, 8'hA5);
    check("R1 latch on pins", pinOut, 8'hA5);
    check("R2 all outputs", pinOe, 8'hFF);
    busWrite(8'h47, 8'h0F);
    check("R2 mixed dir", pinOe, 8'h0F);
  endtask

  task automatic testUnmatched();
    logic [7:0] r;
    busWrite(8'h41, 8'h00);
    busWrite(8'h46, 8'hF0);
    check("R11 pinOut unchanged", pinOut, 8'hA5);
    check("R11 pinOe unchanged", pinOe, 8'h0F);
    busRead(8'h47, r);
    check("R4 dir read zero", r, 8'h00);
    check("R4 pinOe after dir read", pinOe, 8'h0F);
    busRead(8'h12, r);
    check("R4 other addr read zero", r, 8'h00);
  endtask

  task automatic testReadback();
    logic [7:0] r;
    @(negedge clk);
    pinIn = 8'h3C;
    @(negedge clk);
    busAddr = 8'h40; busRdEn = 1'b1; #1;
    check("R5 one edge still old", busRdData, 8'h00);
    @(negedge clk); #1;
    check("R5 two edges new", busRdData, 8'h3C);
    busRdEn = 1'b0;
    setPins(8'h5A);
    busRead(8'h40, r);
    check("R5 output pins read pin level", r, 8'h5A);
  endtask

  task automatic testAux();
    @(negedge clk);
    auxBusEn = 1'b1; auxIoAddr = 6'h2B;
    #1;
    check("R6 aux pinOut", pinOut, {6'h2B, 2'b01});
    check("R6 aux pinOe", pinOe, 8'hFF);
    busWrite(8'h40, 8'h00);
    check("R6 write ignored on claimed pins", {pinOut[7:2], 2'b00}, {6'h2B, 2'b00});
    check("R1 unclaimed pins follow latch", {6'b0, pinOut[1:0]}, 8'h00);
  endtask

  task automatic testSlave();
    logic [7:0] r;
    @(negedge clk);
    auxBusEn = 1'b0; slaveEn = 1'b1; slaveDrive = 6'h31;
    #1;
    check("R7 slave pinOut", {pinOut[7:2], 2'b00}, {6'h31, 2'b00});
    check("R7 slave pinOe", pinOe, 8'hFF);
    setPins(8'h95);
    busRead(8'h40, r);
    check("R7 slave readback", r, 8'hD5);
    @(negedge clk);
    auxBusEn = 1'b1; auxIoAddr = 6'h0A;
    #1;
    check("R8 aux wins over slave", {pinOut[7:2], 2'b00}, {6'h0A, 2'b00});
  endtask

  task automatic testSerial();
    busWrite(8'h47, 8'h00);
    @(negedge clk);
    serBClkEn = 1'b1; serBClk = 1'b1; #1;
    check("R9 serB pin0 high", {7'b0, pinOut[0]}, 8'h01);
    check("R9 serB oe", {7'b0, pinOe[0]}, 8'h01);
    serBClk = 1'b0; #1;
    check("R9 serB pin0 low", {7'b0, pinOut[0]}, 8'h00);
    serAClkEn = 1'b1; serAClk = 1'b1; #1;
    check("R9 serA pin1 with modes on", {6'b0, pinOe[1], pinOut[1]}, 8'h03);
  endtask

  task automatic testRelease();
    busWrite(8'h40, 8'h5A);
    check("R6 pins still claimed", {pinOut[7:2], 2'b00}, {6'h0A, 2'b00});
    busWrite(8'h47, 8'h3C);
    @(negedge clk);
    auxBusEn = 1'b0; slaveEn = 1'b0; serAClkEn = 1'b0; serBClkEn = 1'b0;
    #1;
    check("R10 pinOut back to latch", pinOut, 8'h5A);
    check("R10 pinOe back to dir", pinOe, 8'h3C);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDirData();
    testUnmatched();
    testReadback();
    testAux();
    testSlave();
    testSerial();
    testRelease();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule